// File: doc/BRIEF.md
# Dual Two-Input Qualified Binary Counter

This block holds two independent channels. Each channel is a 4-bit binary up-counter driven by two count pins, `src_a` and `src_b`, which may arrive from slow external logic. Either pin can serve as the count strobe while the other gates it. A rising edge on `src_a` counts when `src_b` is high. A falling edge on `src_b` counts when `src_a` is low. Every other transition leaves the count where it is.

Everything runs on one system clock. Both pins of each channel pass through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. The gating level is taken from that earlier sample. A per-channel active-high clear empties the count at once, without waiting for a clock edge, and blocks counting for as long as it is held.

Top module: `qcnt_dual`

## Requirements
- R1: A low-to-high transition of `src_a` while `src_b` is high raises that channel's count by exactly one.
- R2: A high-to-low transition of `src_b` while `src_a` is low raises that channel's count by exactly one.
- R3: A falling `src_a` or a rising `src_b` never changes the count.
- R4: A rising `src_a` while `src_b` is low, or a falling `src_b` while `src_a` is high, leaves the count unchanged.
- R5: While `clr` of a channel is high, that channel's count reads 0 before the next clock edge, and no transition on its pins changes it.
- R6: After `clr` is released, counting restarts from 0 on the first qualifying transition.
- R7: The count runs 0, 1, ..., 15 and then wraps from 15 to 0.
- R8: The channels are independent: the pins and clear of one channel never change the other channel's count.
- R9: If `src_a` and `src_b` change in the same sample, the count rises by at most one. The gating level used is the level each pin had before that sample.
- R10: While `rst_n` is low, all counts are 0. A qualifying pin change that is set up before system clock edge k shows on `count` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| src_a | input | NCH | Per channel: count pin active on its rising edge, gate for `src_b` when low |
| src_b | input | NCH | Per channel: count pin active on its falling edge, gate for `src_a` when high |
| clr | input | NCH | Per channel: asynchronous active-high clear of the count |
| count | output | NCH*CW | Channel n count in bits [n*CW +: CW] |

## Verification
A corrupted synchronizer or edge history shows up as a count that moves on the wrong transition or misses the right one. It is visible on `count` exactly three clock edges after the pin change that caused it. A fault in the gating level shows only on the disqualified cases (R4) and the same-sample case (R9), so each of these is driven on its own, with the count sampled after the pipeline has settled. A bad count register shows at the 15-to-0 wrap, or as a nonzero value within one clock period of a clear. Crosstalk between channels shows as a change in the idle channel's value, and that value is checked after every step.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  // Synchronized sample of the two count pins of one channel.
  typedef struct packed {
    logic a;
    logic b;
  } pin_pair_t;

  // Qualification rule: a rises with b previously high, or b falls with
  // a previously low.
  function automatic logic qualifies(pin_pair_t cur, pin_pair_t prv);
    logic rule_a;
    logic rule_b;
    rule_a = cur.a & ~prv.a & prv.b;
    rule_b = ~cur.b & prv.b & ~prv.a;
    return rule_a | rule_b;
  endfunction
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qcnt_qualify.sv
module qcnt_qualify
  import qcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_pair_t cur_i,
  output logic      inc_o
);
  pin_pair_t prv_q;
  pin_pair_t prv_d;

  always_comb begin
    prv_d = cur_i;
    inc_o = qualifies(cur_i, prv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= prv_d;
  end
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel
  import qcnt_pkg::*;
#(
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_a_i,
  input  logic          pin_b_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam int PW = $bits(pin_pair_t);

  logic [PW-1:0] sync_q;
  pin_pair_t     cur;
  logic          inc;
  logic          cnt_en;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  qcnt_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({pin_a_i, pin_b_i}),
    .q_o   (sync_q)
  );

  assign cur = pin_pair_t'(sync_q);

  qcnt_qualify u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (cur),
    .inc_o (inc)
  );

  always_comb begin
    cnt_en = inc & ~clr_i;
    cnt_d  = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n or posedge clr_i) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/qcnt_dual.sv
module qcnt_dual #(
  parameter int NCH = 2,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    src_a,
  input  logic [NCH-1:0]    src_b,
  input  logic [NCH-1:0]    clr,
  output logic [NCH*CW-1:0] count
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_int;

  // Asserted at once, released after RST_STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      qcnt_channel #(.CW(CW)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .pin_a_i (src_a[g]),
        .pin_b_i (src_b[g]),
        .clr_i   (clr[g]),
        .cnt_o   (count[g*CW +: CW])
      );
    end
  endgenerate
endmodule

// File: rtl/qcnt_dual_chk.sv
module qcnt_dual_chk #(
  parameter int NCH = 2,
  parameter int CW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    src_a,
  input logic [NCH-1:0]    src_b,
  input logic [NCH-1:0]    clr,
  input logic [NCH*CW-1:0] count
);
  localparam int WARM = 8;
  logic [3:0] warm_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q < WARM) warm_q <= warm_q + 4'd1;
  end
  assign ready = (warm_q == WARM);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      // R5: clear forces zero.
      p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr[g] |-> (count[g*CW +: CW] == '0));

      // R7: the count only steps by one (with wrap) or returns to zero.
      p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (count[g*CW +: CW] != $past(count[g*CW +: CW]))) |->
          ((count[g*CW +: CW] == $past(count[g*CW +: CW]) + 1'b1) ||
           (count[g*CW +: CW] == '0)));

      // R1 / R10: a rising a gated by a high b shows three edges later.
      p_rise_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !clr[g] && !$past(clr[g]) &&
         $past(src_a[g], 3) && !$past(src_a[g], 4) && $past(src_b[g], 4) &&
         $past(src_b[g], 3) == $past(src_b[g], 4)) |->
          (count[g*CW +: CW] == $past(count[g*CW +: CW]) + 1'b1));

      // R2: a falling b gated by a low a counts.
      p_fall_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !clr[g] && !$past(clr[g]) &&
         !$past(src_b[g], 3) && $past(src_b[g], 4) && !$past(src_a[g], 4) &&
         $past(src_a[g], 3) == $past(src_a[g], 4)) |->
          (count[g*CW +: CW] == $past(count[g*CW +: CW]) + 1'b1));

      // R3: quiet pins leave the count alone.
      p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !clr[g] &&
         $past(src_a[g], 3) == $past(src_a[g], 4) &&
         $past(src_b[g], 3) == $past(src_b[g], 4)) |->
          $stable(count[g*CW +: CW]));
    end
  endgenerate
endmodule

bind qcnt_dual qcnt_dual_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .src_a (src_a),
  .src_b (src_b),
  .clr   (clr),
  .count (count)
);

// File: tb/tb_qcnt_dual.sv
module tb_qcnt_dual;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int CW  = 4;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    src_a;
  logic [NCH-1:0]    src_b;
  logic [NCH-1:0]    clr;
  logic [NCH*CW-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int      q_ch  [$];
  int      q_val [$];
  string   q_tag [$];

  int ma [NCH];
  int mb [NCH];
  int mc [NCH];
  int mclr [NCH];

  qcnt_dual #(.NCH(NCH), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .clr(clr), .count(count)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int ch, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, ch, act, exp);
    end
  endtask

  function automatic int cnt_of(int ch);
    return int'(count[ch*CW +: CW]);
  endfunction

  // Driver: change pins of one channel, update the model, let the
  // pipeline settle, then push expected values for every channel.
  task automatic drive(int ch, int na, int nb, string tag);
    int inc;
    @(negedge clk);
    src_a[ch] = na[0];
    src_b[ch] = nb[0];
    inc = ((na == 1 && ma[ch] == 0 && mb[ch] == 1) ||
           (nb == 0 && mb[ch] == 1 && ma[ch] == 0)) ? 1 : 0;
    if (mclr[ch] == 0 && inc == 1) mc[ch] = (mc[ch] + 1) % 16;
    ma[ch] = na;
    mb[ch] = nb;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      q_ch.push_back(c);
      q_val.push_back(mc[c]);
      q_tag.push_back((c == ch) ? tag : "R8");
    end
  endtask

  // Monitor: pop expected items and compare with the outputs.
  initial begin
    forever begin
      wait (q_ch.size() > 0);
      check(q_tag[0], q_ch[0], cnt_of(q_ch[0]), q_val[0]);
      void'(q_ch.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; src_a = '0; src_b = '0; clr = '0;
    for (int c = 0; c < NCH; c++) begin ma[c] = 0; mb[c] = 0; mc[c] = 0; mclr[c] = 0; end
    repeat (3) @(negedge clk);
    check("R10", 0, cnt_of(0), 0);
    check("R10", 1, cnt_of(1), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // Single-pin cases on channel 0
    drive(0, 0, 1, "R3");   // b rises
    drive(0, 1, 1, "R1");   // a rises, b high
    drive(0, 0, 1, "R3");   // a falls
    drive(0, 0, 0, "R2");   // b falls, a low
    drive(0, 1, 0, "R4");   // a rises, b low
    drive(0, 1, 1, "R3");   // b rises
    drive(0, 1, 0, "R4");   // b falls, a high
    drive(0, 0, 0, "R3");   // a falls
    drive(0, 0, 1, "R3");   // b rises
    drive(0, 1, 0, "R9");   // both change in one sample
    drive(0, 0, 0, "R3");
    drive(0, 0, 1, "R3");
    // Run past 15 to check the wrap
    for (int i = 0; i < 14; i++) begin
      drive(0, 1, 1, (mc[0] == 15) ? "R7" : "R1");
      drive(0, 0, 1, "R3");
    end

    // Channel 1 counts on falling b
    for (int i = 0; i < 5; i++) begin
      drive(1, 0, 1, "R3");
      drive(1, 0, 0, "R2");
    end

    // Mid-count clear on channel 1 while channel 0 keeps counting
    @(negedge clk);
    clr[1] = 1'b1; mclr[1] = 1; mc[1] = 0;
    #1;
    check("R5", 1, cnt_of(1), 0);
    drive(1, 0, 1, "R5");
    drive(1, 0, 0, "R5");
    drive(0, 1, 1, "R8");
    drive(0, 0, 1, "R8");
    @(negedge clk);
    clr[1] = 1'b0; mclr[1] = 0;
    repeat (4) @(negedge clk);
    check("R6", 1, cnt_of(1), 0);
    drive(1, 0, 1, "R6");
    drive(1, 0, 0, "R6");

    wait (q_ch.size() == 0);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule